// File: doc/BRIEF.md
# Coprocessor Fault and Maintenance Decoder

This block is the fault-address and maintenance slice of a system-control coprocessor for a small CPU. It keeps a 32-bit fault address register. The register captures the modified virtual address of each data abort reported by the memory system. Instruction-fetch aborts leave it alone. Software can read the register with a coprocessor move, and it can overwrite it with one, for example when a debugger puts back a saved value.

The same access bus carries writes to the cache-maintenance register number (7) and the TLB-maintenance register number (8). Each valid operation becomes a one-cycle command pulse to the unified cache or the unified TLB. A single-entry TLB invalidate also passes the write data along as the address to remove. Any access to register 7 or 8 that is not a defined operation raises an undefined-access pulse instead of a command. All outputs are registered, so every response appears in the cycle after the access.

Top module: `cp_fault_maint`

## Requirements
- R1: While the synchronous active-high reset is applied, the fault address register becomes zero, and cpRdata, cpUndef and all strobes become zero, with tlbInvMva zero.
- R2: A valid read (cpWrite=0) of register number 6 drives the fault address register value on cpRdata in the next cycle. The value is the one held before any update made in the access cycle. In every other cycle cpRdata is zero. CRm and opcode_2 are not checked for register 6.
- R3: A reported fault with faultIsData=1 loads faultMva (the modified virtual address) into the fault address register at the next clock edge.
- R4: A reported fault with faultIsData=0 (prefetch) leaves the fault address register unchanged.
- R5: A valid write of register 6 loads cpWdata into the fault address register. If a data fault is reported in the same cycle, the write wins.
- R6: A valid write to register 7 with opcode_2=3'b000 and CRm=4'b0111 pulses cacheInvAll in the next cycle, whatever cpWdata holds.
- R7: A valid read of register 7 pulses cpUndef in the next cycle.
- R8: A valid write to register 8 with opcode_2=3'b000 and CRm of 5, 6 or 7 pulses tlbInvAll in the next cycle.
- R9: A valid write to register 8 with opcode_2=3'b001 and CRm of 5, 6 or 7 pulses tlbInvEntry in the next cycle, with tlbInvMva equal to the write data. tlbInvMva is zero whenever tlbInvEntry is low.
- R10: Any other access to register 7 or 8, including a read of register 8 or any other opcode_2/CRm pair, pulses cpUndef in the next cycle and produces no strobe.
- R11: Each strobe and cpUndef lasts exactly one cycle per access. Cycles with cpValid low, and accesses to register numbers other than 6, 7 and 8, produce no strobe, no cpUndef and no change to the fault address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpValid | input | 1 | Coprocessor access present this cycle |
| cpWrite | input | 1 | 1 = write to coprocessor, 0 = read |
| cpRegNum | input | 4 | Coprocessor register number |
| cpCrm | input | 4 | CRm field |
| cpOp2 | input | 3 | opcode_2 field |
| cpWdata | input | 32 | Write data |
| faultValid | input | 1 | Abort reported this cycle |
| faultIsData | input | 1 | 1 = data abort, 0 = prefetch abort |
| faultMva | input | 32 | Modified virtual address of the aborted access |
| cpRdata | output | 32 | Read data, one cycle after a register 6 read |
| cpUndef | output | 1 | Undefined-access pulse |
| cacheInvAll | output | 1 | Invalidate whole unified cache |
| tlbInvAll | output | 1 | Invalidate whole unified TLB |
| tlbInvEntry | output | 1 | Invalidate one TLB entry |
| tlbInvMva | output | 32 | Address for the single-entry invalidate |

## Verification
The assertions check on every cycle the update rules of the fault address register: the software write wins, a data abort is captured, and a prefetch abort leaves the register unchanged. They also check that at most one command or undefined pulse appears at a time, that idle cycles stay quiet, and that the invalidate address is zero outside its strobe. Other behaviour needs the bench's scenarios and its cycle-exact reference model to show up. That covers the full decode table of register 7 and 8 fields, including the three accepted CRm values and the boundary values around them. It also covers the old value returned by a read that coincides with a capture, and the absence of any effect from accesses to unrelated register numbers.

// File: rtl/cp_fault_pkg.sv
package cp_fault_pkg;

  // Decoded intent of one coprocessor access, handed from control to datapath
  typedef struct packed {
    logic farWrite;
    logic farRead;
    logic cacheInv;
    logic tlbAll;
    logic tlbOne;
    logic undef;
  } cpStrobes_t;

endpackage

// File: rtl/cp_decode_ctrl.sv
module cp_decode_ctrl
  import cp_fault_pkg::*;
#(
  parameter int REG_W      = 4,
  parameter int CRM_W      = 4,
  parameter int OP2_W      = 3,
  parameter int FAR_REG    = 6,
  parameter int CACHE_REG  = 7,
  parameter int TLB_REG    = 8,
  parameter int CACHE_CRM  = 7,
  parameter int CACHE_OP2  = 0,
  parameter int TLB_CRM_LO = 5,
  parameter int TLB_CRM_HI = 7,
  parameter int TLB_ALL_OP = 0,
  parameter int TLB_ONE_OP = 1
) (
  input  logic             cpValid,
  input  logic             cpWrite,
  input  logic [REG_W-1:0] regNum,
  input  logic [CRM_W-1:0] crm,
  input  logic [OP2_W-1:0] op2,
  output cpStrobes_t       strb
);

  localparam int CRM_CNT = 1 << CRM_W;
  localparam logic [REG_W-1:0] farSel   = REG_W'(FAR_REG);
  localparam logic [REG_W-1:0] cacheSel = REG_W'(CACHE_REG);
  localparam logic [REG_W-1:0] tlbSel   = REG_W'(TLB_REG);

  // Table of CRm values accepted by the TLB operations
  logic [CRM_CNT-1:0] tlbCrmMask;
  for (genvar g = 0; g < CRM_CNT; g++) begin : g_crm
    assign tlbCrmMask[g] = (g >= TLB_CRM_LO) && (g <= TLB_CRM_HI);
  end

  logic hitFar, hitCache, hitTlb;
  logic cacheOk, tlbCrmOk, tlbAllOk, tlbOneOk;

  always_comb begin
    hitFar   = cpValid && (regNum == farSel);
    hitCache = cpValid && (regNum == cacheSel);
    hitTlb   = cpValid && (regNum == tlbSel);
    cacheOk  = cpWrite && (op2 == OP2_W'(CACHE_OP2)) && (crm == CRM_W'(CACHE_CRM));
    tlbCrmOk = tlbCrmMask[crm];
    tlbAllOk = cpWrite && tlbCrmOk && (op2 == OP2_W'(TLB_ALL_OP));
    tlbOneOk = cpWrite && tlbCrmOk && (op2 == OP2_W'(TLB_ONE_OP));

    strb          = '0;
    strb.farWrite = hitFar && cpWrite;
    strb.farRead  = hitFar && !cpWrite;
    strb.cacheInv = hitCache && cacheOk;
    strb.tlbAll   = hitTlb && tlbAllOk;
    strb.tlbOne   = hitTlb && tlbOneOk;
    strb.undef    = (hitCache && !cacheOk) || (hitTlb && !tlbAllOk && !tlbOneOk);
  end

endmodule

// File: rtl/cp_fault_dp.sv
module cp_fault_dp
  import cp_fault_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  cpStrobes_t        strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic              faultValid,
  input  logic              faultIsData,
  input  logic [DATA_W-1:0] faultMva,
  output logic [DATA_W-1:0] rdata,
  output logic              undef,
  output logic              cacheInv,
  output logic              tlbAll,
  output logic              tlbOne,
  output logic [DATA_W-1:0] tlbMva
);

  logic [DATA_W-1:0] farQ;
  logic              captureData;

  assign captureData = faultValid && faultIsData;

  // Fault address register: software write has priority over abort capture
  always_ff @(posedge clk) begin
    if (rst)                farQ <= '0;
    else if (strb.farWrite) farQ <= wdata;
    else if (captureData)   farQ <= faultMva;
  end

  // Registered responses, each live for one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      undef    <= 1'b0;
      cacheInv <= 1'b0;
      tlbAll   <= 1'b0;
      tlbOne   <= 1'b0;
      tlbMva   <= '0;
    end else begin
      rdata    <= strb.farRead ? farQ : '0;
      undef    <= strb.undef;
      cacheInv <= strb.cacheInv;
      tlbAll   <= strb.tlbAll;
      tlbOne   <= strb.tlbOne;
      tlbMva   <= strb.tlbOne ? wdata : '0;
    end
  end

  p_write_wins_r5: assert property (@(posedge clk) disable iff (rst)
    strb.farWrite |=> farQ == $past(wdata));

  p_data_capture_r3: assert property (@(posedge clk) disable iff (rst)
    faultValid && faultIsData && !strb.farWrite |=> farQ == $past(faultMva));

  p_prefetch_hold_r4: assert property (@(posedge clk) disable iff (rst)
    faultValid && !faultIsData && !strb.farWrite |=> $stable(farQ));

  p_one_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({undef, cacheInv, tlbAll, tlbOne}));

endmodule

// File: rtl/cp_fault_maint.sv
module cp_fault_maint
  import cp_fault_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 4,
  parameter int CRM_W  = 4,
  parameter int OP2_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpValid,
  input  logic              cpWrite,
  input  logic [REG_W-1:0]  cpRegNum,
  input  logic [CRM_W-1:0]  cpCrm,
  input  logic [OP2_W-1:0]  cpOp2,
  input  logic [DATA_W-1:0] cpWdata,
  input  logic              faultValid,
  input  logic              faultIsData,
  input  logic [DATA_W-1:0] faultMva,
  output logic [DATA_W-1:0] cpRdata,
  output logic              cpUndef,
  output logic              cacheInvAll,
  output logic              tlbInvAll,
  output logic              tlbInvEntry,
  output logic [DATA_W-1:0] tlbInvMva
);

  cpStrobes_t strb;

  cp_decode_ctrl #(
    .REG_W(REG_W), .CRM_W(CRM_W), .OP2_W(OP2_W)
  ) u_ctrl (
    .cpValid(cpValid),
    .cpWrite(cpWrite),
    .regNum (cpRegNum),
    .crm    (cpCrm),
    .op2    (cpOp2),
    .strb   (strb)
  );

  cp_fault_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .wdata      (cpWdata),
    .faultValid (faultValid),
    .faultIsData(faultIsData),
    .faultMva   (faultMva),
    .rdata      (cpRdata),
    .undef      (cpUndef),
    .cacheInv   (cacheInvAll),
    .tlbAll     (tlbInvAll),
    .tlbOne     (tlbInvEntry),
    .tlbMva     (tlbInvMva)
  );

  p_read7_undef_r7: assert property (@(posedge clk) disable iff (rst)
    cpValid && !cpWrite && cpRegNum == REG_W'(7) |=> cpUndef);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !cpValid |=> !cpUndef && !cacheInvAll && !tlbInvAll && !tlbInvEntry && cpRdata == '0);

  p_mva_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !tlbInvEntry |-> tlbInvMva == '0);

endmodule

// File: tb/sim_cp_fault_maint.sv
module sim_cp_fault_maint;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpValid = 0, cpWrite = 0, faultValid = 0, faultIsData = 0;
  logic [3:0]  cpRegNum = 0, cpCrm = 0;
  logic [2:0]  cpOp2 = 0;
  logic [31:0] cpWdata = 0, faultMva = 0;
  logic [31:0] cpRdata, tlbInvMva;
  logic        cpUndef, cacheInvAll, tlbInvAll, tlbInvEntry;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] mFar = 0;

  always #10 clk = ~clk;  // 50 MHz

  cp_fault_maint u0 (.*);

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One clock: apply inputs, predict, clock, compare
  task automatic cyc(string tag, logic r, logic v, logic w, int rn, int cm, int o2,
                     logic [31:0] wd, logic fv, logic fd, logic [31:0] fm);
    logic [31:0] eRd = 0, eMva = 0;
    logic eU = 0, eC = 0, eTa = 0, eTo = 0;
    bit tlbCrm;
    rst = r; cpValid = v; cpWrite = w; cpRegNum = 4'(rn); cpCrm = 4'(cm); cpOp2 = 3'(o2);
    cpWdata = wd; faultValid = fv; faultIsData = fd; faultMva = fm;
    tlbCrm = (cm >= 5) && (cm <= 7);
    if (r) mFar = 0;
    else begin
      if (v) begin
        case (rn)
          6: if (!w) eRd = mFar;
          7: if (w && o2 == 0 && cm == 7) eC = 1; else eU = 1;
          8: begin
            if (w && tlbCrm && o2 == 0) eTa = 1;
            else if (w && tlbCrm && o2 == 1) begin eTo = 1; eMva = wd; end
            else eU = 1;
          end
          default: ;
        endcase
      end
      if (v && w && rn == 6) mFar = wd;
      else if (fv && fd) mFar = fm;
    end
    @(posedge clk);
    #2;
    chk(tag, "cpRdata", cpRdata, eRd);
    chk(tag, "cpUndef", 32'(cpUndef), 32'(eU));
    chk(tag, "cacheInvAll", 32'(cacheInvAll), 32'(eC));
    chk(tag, "tlbInvAll", 32'(tlbInvAll), 32'(eTa));
    chk(tag, "tlbInvEntry", 32'(tlbInvEntry), 32'(eTo));
    chk(tag, "tlbInvMva", tlbInvMva, eMva);
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, 0, 0, 0, 0, 32'h0, 0, 0, 32'h0);
  endtask

  task automatic rdFar(string tag);
    cyc(tag, 0, 1, 0, 6, 0, 0, 32'h0, 0, 0, 32'h0);
  endtask

  initial begin
    // R1: reset state
    cyc("R1", 1, 1, 1, 8, 5, 1, 32'hFFFF_FFFF, 1, 1, 32'h1234_5678);
    cyc("R1", 1, 0, 0, 0, 0, 0, 32'h0, 0, 0, 32'h0);
    rdFar("R1");
    idle("R2");
    // R5 / R2: software write then read back
    cyc("R5", 0, 1, 1, 6, 0, 0, 32'hA5A5_0001, 0, 0, 32'h0);
    rdFar("R2");
    idle("R2");
    // R3: data abort capture
    cyc("R3", 0, 0, 0, 0, 0, 0, 32'h0, 1, 1, 32'hBEEF_0100);
    rdFar("R3");
    // R4: prefetch abort ignored
    cyc("R4", 0, 0, 0, 0, 0, 0, 32'h0, 1, 0, 32'hDEAD_0200);
    rdFar("R4");
    // R5: write beats simultaneous data abort
    cyc("R5", 0, 1, 1, 6, 3, 5, 32'h0000_D00D, 1, 1, 32'h1111_2222);
    rdFar("R5");
    // R2: read in same cycle as capture returns old value
    cyc("R2", 0, 1, 0, 6, 0, 0, 32'h0, 1, 1, 32'hCAFE_0300);
    rdFar("R3");
    // R6: cache invalidate, data ignored
    cyc("R6", 0, 1, 1, 7, 7, 0, 32'hFFFF_FFFF, 0, 0, 32'h0);
    cyc("R6", 0, 1, 1, 7, 7, 0, 32'h0, 0, 0, 32'h0);
    idle("R11");
    // R10: wrong cache fields
    cyc("R10", 0, 1, 1, 7, 6, 0, 32'h0, 0, 0, 32'h0);
    cyc("R10", 0, 1, 1, 7, 7, 1, 32'h0, 0, 0, 32'h0);
    // R7: read of register 7
    cyc("R7", 0, 1, 0, 7, 7, 0, 32'h0, 0, 0, 32'h0);
    // R8: whole TLB, each accepted CRm, plus neighbours
    for (int c = 4; c <= 8; c++) cyc((c >= 5 && c <= 7) ? "R8" : "R10", 0, 1, 1, 8, c, 0, 32'h55, 0, 0, 32'h0);
    // R9: single entry
    for (int c = 4; c <= 8; c++) cyc((c >= 5 && c <= 7) ? "R9" : "R10", 0, 1, 1, 8, c, 1, 32'h8000_0000 + 32'(c), 0, 0, 32'h0);
    // R10: other opcode_2, read of 8
    cyc("R10", 0, 1, 1, 8, 6, 2, 32'h77, 0, 0, 32'h0);
    cyc("R10", 0, 1, 0, 8, 6, 1, 32'h77, 0, 0, 32'h0);
    // R11: unrelated register, idle with decode fields
    cyc("R11", 0, 1, 1, 3, 7, 0, 32'h9999_9999, 0, 0, 32'h0);
    cyc("R11", 0, 0, 1, 7, 7, 0, 32'h0, 0, 0, 32'h0);
    cyc("R11", 0, 0, 1, 6, 0, 0, 32'h4444_4444, 0, 0, 32'h0);
    rdFar("R11");
    // Mixed traffic
    for (int i = 0; i < 400; i++) begin
      int rn = 5 + int'($urandom % 5);
      cyc("R11", 0, 1'($urandom), 1'($urandom), rn, int'($urandom % 16), int'($urandom % 4),
          $urandom, 1'($urandom), 1'($urandom), $urandom);
    end
    // R1: reset mid-run clears the register
    cyc("R1", 1, 0, 0, 0, 0, 0, 32'h0, 0, 0, 32'h0);
    rdFar("R1");
    idle("R2");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(20 * 50000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule